// File: doc/BRIEF.md
# Pipeline Hazard and Operand Bypass Controller

This block decides, every cycle, where each operand of a five-stage in-order pipeline (Fetch, Decode/register read, Execute, Memory, Writeback) comes from, and when the front of the pipeline has to wait. It is fed the instruction word sitting in the Fetch/Decode register. It decodes only the register fields that matter for hazards. It then keeps its own copy of those fields for the Execute, Memory and Writeback stages, moving them along in step with the datapath pipeline registers.

There are three kinds of result. Two-bit selects steer the Execute-stage operand multiplexers: register-file value, Memory-stage result or Writeback result. One-bit selects in Decode swap the register-file read for the Writeback result. This covers the case where the register file does not write before it reads in the same cycle. A stall line holds the PC and the Fetch/Decode register for one cycle and puts a bubble into Decode/Execute. The register file, ALU, memories and branch resolution sit outside. Store data and branch comparison operands use the same selects as ALU operands, so they are simply the A and B operands of their instruction.

Every pin is a plain level-sensitive control signal. The decode input has no handshake: a low `id_valid` marks the slot as empty.

Top module: `hzu_core`

## Requirements
- R1: While reset is asserted, and in the first cycles after it, every pipeline stage counts as a NOP. All selects are 0 and the stall is low, whatever word is being decoded.
- R2: Select encoding is 0 for the register-file value, 1 for the Memory-stage result and 2 for the Writeback result. Operand A is the rs field, bits [25:21]. Operand B is the rt field, bits [20:16]. An Execute operand whose register is written by the instruction one ahead (now in Memory) selects 1.
- R3: An Execute operand whose register is written by the instruction two ahead (now in Writeback) selects 2.
- R4: When both the Memory and Writeback stages write the register an Execute operand reads, the select is 1 (the younger result wins).
- R5: Register 0 never causes forwarding and never causes a stall, whether it is the destination or the source.
- R6: A Decode operand whose register is being written in Writeback in the same cycle drives its Decode select (id_fwd_a / id_fwd_b) to 1.
- R7: If the Execute stage holds LW with destination d, and the decoded instruction reads d, stall is high for exactly one cycle and Execute then holds a bubble. When the consumer reaches Execute it takes the loaded value with select 2. No select ever picks a load that is in the Memory stage.
- R8: A load followed by an independent instruction, or a consumer two instructions after the load, causes no stall. That consumer gets select 2.
- R9: Source use by instruction (opcode bits [31:26], funct bits [5:0]): ADDU 0x21, SUBU 0x23 and AND 0x24 (opcode 0) read rs and rt. SRL (funct 0x02) reads only rt, and its rs field is ignored. ADDIU 0x09 and LW 0x23 read rs. SW 0x2B, BEQ 0x04 and BNE 0x05 read rs and rt.
- R10: Destination by instruction: R-type writes rd (bits [15:11]). ADDIU and LW write rt. SW, BEQ and BNE write no register, and the bits of an immediate are never a destination.
- R11: A Decode slot with id_valid low reads and writes nothing. It causes no stall and no Decode forwarding, and it travels down the pipeline as a bubble.
- R12: Any other opcode or funct is a NOP: no sources, no destination, no load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_valid | input | 1 | Fetch/Decode register holds a real instruction |
| id_insn | input | 32 | Instruction word in the Decode stage |
| lu_stall | output | 1 | Load-use stall: hold PC and Fetch/Decode, bubble into Decode/Execute |
| ex_fwd_a | output | 2 | Execute operand A (rs) source select |
| ex_fwd_b | output | 2 | Execute operand B (rt) source select |
| id_fwd_a | output | 1 | Decode operand A takes the Writeback result |
| id_fwd_b | output | 1 | Decode operand B takes the Writeback result |

## Verification
`lu_stall`, `id_fwd_a` and `id_fwd_b` are combinational in the word being decoded. They are due in the same cycle that word is presented. `ex_fwd_a` and `ex_fwd_b` describe the instruction presented one accepted cycle earlier, which now sits in Execute. After a stall that instruction is the re-presented word and not the bubble. The driver presents each word one nanosecond after a rising edge and queues the outputs expected for that cycle, worked out by hand from stage contents. The monitor compares them at the following falling edge, before the next edge moves the pipeline.

// File: rtl/hzu_pkg.sv
package hzu_pkg;

  localparam int unsigned INSN_W  = 32;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned NUM_SRC = 2;   // operand A = rs, operand B = rt
  localparam int unsigned N_STG   = 3;   // tracked stages: Execute, Memory, Writeback

  localparam int unsigned STG_EX  = 0;
  localparam int unsigned STG_MEM = 1;
  localparam int unsigned STG_WB  = 2;

  // field positions of the instruction word
  localparam int unsigned OP_LSB  = 26;
  localparam int unsigned RS_LSB  = 21;
  localparam int unsigned RT_LSB  = 16;
  localparam int unsigned RD_LSB  = 11;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned FN_W    = 6;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_ADDIU = 6'h09;
  localparam logic [OP_W-1:0] OPC_LW    = 6'h23;
  localparam logic [OP_W-1:0] OPC_SW    = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'h05;

  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_MEM = 2'd1,
    FWD_WB  = 2'd2
  } fwd_e;

  // hazard-relevant view of one instruction; all-zero is a NOP
  typedef struct packed {
    logic [NUM_SRC-1:0]             src_en;
    logic [NUM_SRC-1:0][REG_AW-1:0] src;
    logic                           wr;
    logic [REG_AW-1:0]              dst;
    logic                           ld;
  } stage_ctl_t;

  localparam stage_ctl_t CTL_NOP = '0;

endpackage

// File: rtl/hzu_decode.sv
module hzu_decode
  import hzu_pkg::*;
(
  input  logic              valid,
  input  logic [INSN_W-1:0] insn,
  output stage_ctl_t        ctl
);

  logic [OP_W-1:0]   opc;
  logic [FN_W-1:0]   fn;
  logic [REG_AW-1:0] f_rs;
  logic [REG_AW-1:0] f_rt;
  logic [REG_AW-1:0] f_rd;
  stage_ctl_t        raw;

  assign opc  = insn[OP_LSB +: OP_W];
  assign fn   = insn[0 +: FN_W];
  assign f_rs = insn[RS_LSB +: REG_AW];
  assign f_rt = insn[RT_LSB +: REG_AW];
  assign f_rd = insn[RD_LSB +: REG_AW];

  always_comb begin
    raw        = CTL_NOP;
    raw.src[0] = f_rs;
    raw.src[1] = f_rt;
    if (valid) begin
      case (opc)
        OPC_RTYPE: begin
          case (fn)
            FN_ADDU, FN_SUBU, FN_AND: begin
              raw.src_en = 2'b11;
              raw.wr     = 1'b1;
              raw.dst    = f_rd;
            end
            FN_SRL: begin
              raw.src_en = 2'b10;     // shift source is rt only
              raw.wr     = 1'b1;
              raw.dst    = f_rd;
            end
            default: ;
          endcase
        end
        OPC_ADDIU: begin
          raw.src_en = 2'b01;
          raw.wr     = 1'b1;
          raw.dst    = f_rt;
        end
        OPC_LW: begin
          raw.src_en = 2'b01;
          raw.wr     = 1'b1;
          raw.dst    = f_rt;
          raw.ld     = 1'b1;
        end
        OPC_SW, OPC_BEQ, OPC_BNE: begin
          raw.src_en = 2'b11;
        end
        default: ;
      endcase
    end
  end

  // register 0 is neither a dependence source nor a forwarding target
  always_comb begin
    ctl = raw;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (raw.src[i] == '0) ctl.src_en[i] = 1'b0;
    end
    if (raw.dst == '0) begin
      ctl.wr = 1'b0;
      ctl.ld = 1'b0;
    end
  end

endmodule

// File: rtl/hzu_stage_track.sv
module hzu_stage_track
  import hzu_pkg::*;
#(
  parameter int unsigned DEPTH = N_STG
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold,
  input  stage_ctl_t dec_ctl,
  output stage_ctl_t stg_q [DEPTH]
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    stage_ctl_t nxt;
    if (g == 0) begin : g_head
      // a held decode slot leaves a bubble behind it
      assign nxt = hold ? CTL_NOP : dec_ctl;
    end else begin : g_tail
      assign nxt = stg_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[g] <= CTL_NOP;
      else        stg_q[g] <= nxt;
    end
  end

endmodule

// File: rtl/hzu_fwd_pick.sv
module hzu_fwd_pick
  import hzu_pkg::*;
#(
  parameter bit USE_NEAR = 1'b1
)(
  input  logic              src_en,
  input  logic [REG_AW-1:0] src,
  input  stage_ctl_t        near_ctl,
  input  stage_ctl_t        far_ctl,
  output fwd_e              sel
);

  logic hit_near;
  logic hit_far;

  if (USE_NEAR) begin : g_near
    assign hit_near = src_en && near_ctl.wr && (near_ctl.dst == src);
  end else begin : g_no_near
    assign hit_near = 1'b0;
  end

  assign hit_far = src_en && far_ctl.wr && (far_ctl.dst == src);

  // the younger producer wins
  always_comb begin
    if (hit_near)     sel = FWD_MEM;
    else if (hit_far) sel = FWD_WB;
    else              sel = FWD_RF;
  end

endmodule

// File: rtl/hzu_loaduse.sv
module hzu_loaduse
  import hzu_pkg::*;
(
  input  stage_ctl_t dec_ctl,
  input  stage_ctl_t ex_ctl,
  output logic       stall
);

  logic [NUM_SRC-1:0] hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign hit[s] = dec_ctl.src_en[s] && (dec_ctl.src[s] == ex_ctl.dst);
  end

  assign stall = ex_ctl.ld && ex_ctl.wr && (|hit);

endmodule

// File: rtl/hzu_core.sv
module hzu_core
  import hzu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [INSN_W-1:0] id_insn,
  output logic              lu_stall,
  output logic [1:0]        ex_fwd_a,
  output logic [1:0]        ex_fwd_b,
  output logic              id_fwd_a,
  output logic              id_fwd_b
);

  stage_ctl_t id_ctl;
  stage_ctl_t stg_q [N_STG];
  stage_ctl_t ex_ctl;
  stage_ctl_t mem_ctl;
  stage_ctl_t wb_ctl;
  fwd_e       ex_sel [NUM_SRC];
  fwd_e       id_sel [NUM_SRC];

  hzu_decode u_dec (
    .valid (id_valid),
    .insn  (id_insn),
    .ctl   (id_ctl)
  );

  hzu_stage_track #(.DEPTH(N_STG)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold    (lu_stall),
    .dec_ctl (id_ctl),
    .stg_q   (stg_q)
  );

  assign ex_ctl  = stg_q[STG_EX];
  assign mem_ctl = stg_q[STG_MEM];
  assign wb_ctl  = stg_q[STG_WB];

  hzu_loaduse u_lu (
    .dec_ctl (id_ctl),
    .ex_ctl  (ex_ctl),
    .stall   (lu_stall)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_opnd
    hzu_fwd_pick #(.USE_NEAR(1'b1)) u_ex_pick (
      .src_en   (ex_ctl.src_en[s]),
      .src      (ex_ctl.src[s]),
      .near_ctl (mem_ctl),
      .far_ctl  (wb_ctl),
      .sel      (ex_sel[s])
    );

    hzu_fwd_pick #(.USE_NEAR(1'b0)) u_id_pick (
      .src_en   (id_ctl.src_en[s]),
      .src      (id_ctl.src[s]),
      .near_ctl (CTL_NOP),
      .far_ctl  (wb_ctl),
      .sel      (id_sel[s])
    );
  end

  assign ex_fwd_a = ex_sel[0];
  assign ex_fwd_b = ex_sel[1];
  assign id_fwd_a = (id_sel[0] == FWD_WB);
  assign id_fwd_b = (id_sel[1] == FWD_WB);

endmodule

// File: rtl/hzu_core_chk.sv
module hzu_core_chk
  import hzu_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       id_valid,
  input logic       lu_stall,
  input logic [1:0] ex_fwd_a,
  input logic [1:0] ex_fwd_b,
  input logic       id_fwd_a,
  input logic       id_fwd_b,
  input stage_ctl_t id_ctl,
  input stage_ctl_t ex_ctl,
  input stage_ctl_t mem_ctl,
  input stage_ctl_t wb_ctl
);

  // R7
  stall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |=> !lu_stall);

  // R7
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lu_stall |=> (!ex_ctl.wr && !ex_ctl.ld && ex_ctl.src_en == '0));

  // R7
  no_load_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == FWD_MEM || ex_fwd_b == FWD_MEM) |-> !mem_ctl.ld);

  // R5
  mem_dst_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == FWD_MEM || ex_fwd_b == FWD_MEM) |-> (mem_ctl.dst != '0));

  // R4
  younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_fwd_a == FWD_WB) |-> !(mem_ctl.wr && mem_ctl.dst == ex_ctl.src[0]));

  // R6
  id_bypass_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_fwd_a |-> (wb_ctl.wr && wb_ctl.dst == id_ctl.src[0] && wb_ctl.dst != '0));

  // R11
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> (!lu_stall && !id_fwd_a && !id_fwd_b));

  // R11
  idle_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |=> (ex_ctl.src_en == '0 && !ex_ctl.wr));

endmodule

bind hzu_core hzu_core_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .id_valid (id_valid),
  .lu_stall (lu_stall),
  .ex_fwd_a (ex_fwd_a),
  .ex_fwd_b (ex_fwd_b),
  .id_fwd_a (id_fwd_a),
  .id_fwd_b (id_fwd_b),
  .id_ctl   (id_ctl),
  .ex_ctl   (ex_ctl),
  .mem_ctl  (mem_ctl),
  .wb_ctl   (wb_ctl)
);

// File: tb/hzu_core_test.sv
`timescale 1ns/1ps
module hzu_core_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        id_valid;
  logic [31:0] id_insn;
  logic        lu_stall;
  logic [1:0]  ex_fwd_a;
  logic [1:0]  ex_fwd_b;
  logic        id_fwd_a;
  logic        id_fwd_b;

  always #2 clk = ~clk;   // 250 MHz

  hzu_core uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .id_valid (id_valid),
    .id_insn  (id_insn),
    .lu_stall (lu_stall),
    .ex_fwd_a (ex_fwd_a),
    .ex_fwd_b (ex_fwd_b),
    .id_fwd_a (id_fwd_a),
    .id_fwd_b (id_fwd_b)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  bit    finished = 1'b0;
  logic [6:0] exp_q [$];
  string      tag_q [$];
  logic [6:0] m_exp;
  logic [6:0] m_got;
  string      m_tag;

  // encoders written from the field layout in the requirements
  function automatic logic [31:0] r_op(input logic [5:0] fn, input int rd, input int rs,
                                       input int rt, input int sh);
    return {6'h00, rs[4:0], rt[4:0], rd[4:0], sh[4:0], fn};
  endfunction
  function automatic logic [31:0] i_op(input logic [5:0] op, input int rt, input int rs,
                                       input logic [15:0] imm);
    return {op, rs[4:0], rt[4:0], imm};
  endfunction
  function automatic logic [31:0] addu(input int d, input int s, input int t);
    return r_op(6'h21, d, s, t, 0);
  endfunction
  function automatic logic [31:0] lw(input int t, input int s);
    return i_op(6'h23, t, s, 16'h0004);
  endfunction

  localparam logic [31:0] NOP = 32'h0;

  task automatic step(input logic v, input logic [31:0] w, input logic st,
                      input logic [1:0] ea, input logic [1:0] eb,
                      input logic ia, input logic ib, input string tag);
    @(posedge clk);
    #1;
    id_valid = v;
    id_insn  = w;
    exp_q.push_back({st, ea, eb, ia, ib});
    tag_q.push_back(tag);
  endtask

  // monitor: compares at the falling edge of the cycle the item was queued
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      m_exp = exp_q.pop_front();
      m_tag = tag_q.pop_front();
      m_got = {lu_stall, ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b};
      n_chk++;
      if (m_got !== m_exp) begin
        n_bad++;
        $display("FAIL %s: stall=%b exa=%0d exb=%0d ida=%b idb=%b, expected stall=%b exa=%0d exb=%0d ida=%b idb=%b",
                 m_tag, m_got[6], m_got[5:4], m_got[3:2], m_got[1], m_got[0],
                 m_exp[6], m_exp[5:4], m_exp[3:2], m_exp[1], m_exp[0]);
      end
    end
  end

  initial begin
    #20000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    id_valid = 1'b0;
    id_insn  = NOP;
    repeat (2) @(posedge clk);
    // R1: a load in decode during reset sees only NOPs downstream
    step(1, lw(3, 2), 0, 0, 0, 0, 0, "R1 reset");
    step(1, addu(5, 3, 3), 0, 0, 0, 0, 0, "R1 reset hold");
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    id_valid = 1'b0;
    id_insn = NOP;

    // bypass distances and priority
    step(1, addu(1, 2, 3),  0, 0, 0, 0, 0, "R1 after reset");
    step(1, addu(4, 1, 1),  0, 0, 0, 0, 0, "R2 setup");
    step(1, addu(5, 1, 4),  0, 1, 1, 0, 0, "R2 mem bypass");
    step(1, addu(7, 1, 2),  0, 2, 1, 1, 0, "R3 wb bypass, R6 decode bypass");
    step(1, NOP,            0, 0, 0, 0, 0, "R2 idle");
    step(1, addu(8, 2, 3),  0, 0, 0, 0, 0, "R4 setup");
    step(1, addu(8, 8, 3),  0, 0, 0, 0, 0, "R4 setup");
    step(1, addu(9, 8, 8),  0, 1, 0, 0, 0, "R2 mem bypass a");
    step(1, addu(10, 5, 8), 0, 1, 1, 0, 1, "R4 younger wins, R6 decode b");
    step(1, NOP,            0, 0, 2, 0, 0, "R3 wb bypass b");
    step(1, NOP,            0, 0, 0, 0, 0, "R3 drain");

    // register 0
    step(1, addu(0, 2, 3),  0, 0, 0, 0, 0, "R5 setup");
    step(1, addu(11, 0, 0), 0, 0, 0, 0, 0, "R5 setup");
    step(1, NOP,            0, 0, 0, 0, 0, "R5 r0 not forwarded in execute");
    step(1, addu(12, 0, 0), 0, 0, 0, 0, 0, "R5 r0 not forwarded in decode");
    step(1, lw(0, 2),       0, 0, 0, 0, 0, "R5 setup");
    step(1, addu(13, 0, 0), 0, 0, 0, 0, 0, "R5 load to r0 no stall");
    step(1, NOP,            0, 0, 0, 0, 0, "R5 drain");
    step(1, NOP,            0, 0, 0, 0, 0, "R5 drain");
    step(1, NOP,            0, 0, 0, 0, 0, "R5 drain");

    // load-use
    step(1, lw(14, 2),       0, 0, 0, 0, 0, "R7 setup");
    step(1, addu(15, 14, 3), 1, 0, 0, 0, 0, "R7 stall");
    step(1, addu(15, 14, 3), 0, 0, 0, 0, 0, "R7 single stall, bubble");
    step(1, NOP,             0, 2, 0, 0, 0, "R7 load value from writeback");
    step(1, NOP,             0, 0, 0, 0, 0, "R7 drain");
    step(1, lw(16, 2),                        0, 0, 0, 0, 0, "R7 setup");
    step(1, i_op(6'h2B, 16, 3, 16'h0008),     1, 0, 0, 0, 0, "R7 store data stall");
    step(1, i_op(6'h2B, 16, 3, 16'h0008),     0, 0, 0, 0, 0, "R7 store released");
    step(1, NOP,                              0, 0, 2, 0, 0, "R9 store data bypass");

    // load without immediate use
    step(1, lw(17, 2),       0, 0, 0, 0, 0, "R8 setup");
    step(1, addu(18, 2, 3),  0, 0, 0, 0, 0, "R8 independent no stall");
    step(1, addu(19, 17, 17),0, 0, 0, 0, 0, "R8 distance two no stall");
    step(1, NOP,             0, 2, 2, 0, 0, "R8 distance two wb bypass");

    // per-instruction source and destination fields
    step(1, r_op(6'h02, 20, 19, 19, 4),     0, 0, 0, 0, 0, "R9 srl decode");
    step(1, NOP,                            0, 0, 2, 0, 0, "R9 srl ignores rs");
    step(1, i_op(6'h09, 22, 2, 16'hB800),   0, 0, 0, 0, 0, "R10 addiu");
    step(1, addu(24, 22, 23),               0, 0, 0, 0, 0, "R10 setup");
    step(1, NOP,                            0, 1, 0, 0, 0, "R10 addiu writes rt not imm");
    step(1, i_op(6'h2B, 25, 2, 16'h0000),   0, 0, 0, 0, 0, "R10 store");
    step(1, i_op(6'h04, 25, 25, 16'h0003),  0, 0, 0, 0, 0, "R10 beq");
    step(1, NOP,                            0, 0, 0, 0, 0, "R10 store writes nothing");
    step(1, NOP,                            0, 0, 0, 0, 0, "R10 drain");
    step(1, addu(28, 2, 3),                 0, 0, 0, 0, 0, "R9 setup");
    step(1, i_op(6'h05, 28, 28, 16'h0002),  0, 0, 0, 0, 0, "R9 bne");
    step(1, NOP,                            0, 1, 1, 0, 0, "R9 branch operands bypassed");
    step(1, lw(29, 2),                      0, 0, 0, 0, 0, "R7 setup");
    step(1, i_op(6'h04, 0, 29, 16'h0001),   1, 0, 0, 0, 0, "R7 branch after load stalls");
    step(1, i_op(6'h04, 0, 29, 16'h0001),   0, 0, 0, 0, 0, "R7 branch released");
    step(1, NOP,                            0, 2, 0, 0, 0, "R7 branch gets loaded value");

    // empty decode slot
    step(1, lw(30, 2),        0, 0, 0, 0, 0, "R11 setup");
    step(0, addu(31, 30, 30), 0, 0, 0, 0, 0, "R11 invalid slot no stall");
    step(1, NOP,              0, 0, 0, 0, 0, "R11 invalid slot is a bubble");

    // unsupported encodings
    step(1, i_op(6'h0D, 5, 6, 16'h00FF), 0, 0, 0, 0, 0, "R12 unknown opcode");
    step(1, addu(7, 5, 5),               0, 0, 0, 0, 0, "R12 setup");
    step(1, NOP,                         0, 0, 0, 0, 0, "R12 unknown writes nothing");
    step(1, i_op(6'h20, 9, 2, 16'h0000), 0, 0, 0, 0, 0, "R12 unknown load-like");
    step(1, addu(1, 9, 9),               0, 0, 0, 0, 0, "R12 no stall after unknown");
    step(1, NOP,                         0, 0, 0, 0, 0, "R12 no bypass from unknown");

    @(posedge clk);
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule